// File: doc/BRIEF.md
# Serial Line Idle Pattern Detector

This block watches the receive side of a bit-serial data-link line and tells the rest of the receiver when the line has gone idle. Bits arrive one per cycle in which `bit_valid` is high; cycles with the strobe low are pauses and change nothing. Two idle conditions are tracked. In a mark idle, the line holds a long unbroken run of ones. In a flag idle, it carries flag characters (01111110, 0x7E) one after another, with no data between them.

Each condition is given as a level and as a one-cycle pulse in the cycle the level rises. Both are plain status and raise no interrupt. Mark idle comes from a saturating counter of consecutive ones. Flag idle comes from a small state machine fed by an 8-bit window over the most recent bits. The machine has three states:
- `ST_HUNT` searches for a flag at every bit position.
- `ST_COUNT` is locked to octet boundaries and counts flags.
- `ST_FLAG_IDLE` is the idle state.

Its transitions are:
- hunt-to-count: any bit that completes a flag in the window.
- count-to-count: a flag octet while fewer than three flags have been counted.
- count-to-idle: the octet that completes the third counted flag.
- idle-to-idle: further flag octets.
- count-or-idle-to-hunt: a non-flag octet.
- any-to-hunt: the seventh one in a row (abort).

The first flag found while hunting is taken as a frame's closing flag and is not counted. Flags are assumed to be octet-aligned and back to back, with no shared zeros.

Top module: `idle_line_monitor`

## Requirements
- R1: While reset is active and in the first cycle after its release, `mark_idle`, `flag_idle`, `mark_idle_rise` and `flag_idle_rise` are all 0.
- R2: `mark_idle` becomes 1 at the clock edge that samples the 15th consecutive valid one bit. It stays 1 while further one bits arrive.
- R3: The ones run counter saturates at 15. A valid zero bit clears `mark_idle` at the edge that samples it, and counting starts again from zero. A run of 14 ones followed by a zero never sets `mark_idle`.
- R4: `mark_idle_rise` and `flag_idle_rise` are each high for exactly one cycle, in the same cycle their level first reads 1. They do not pulse again while the level stays 1.
- R5: The flag pattern is 8'h7E (01111110), matched against the last eight valid bits. In `ST_HUNT` it is matched at every bit. The first match is treated as a closing flag: it moves to `ST_COUNT` with a count of zero. From then on, only the octet made of each next group of eight valid bits is checked.
- R6: `flag_idle` becomes 1 at the edge that samples the last bit of the third flag octet counted after the closing flag. This is the fourth back-to-back flag in total. Two or three back-to-back flags never set it.
- R7: A completed octet that is not 8'h7E, seen in `ST_COUNT` or `ST_FLAG_IDLE`, clears `flag_idle` and the flag count at that edge and returns to `ST_HUNT`. A later flag is then again a closing flag.
- R8: The seventh consecutive valid one bit is an abort. At that edge it clears `flag_idle` and the flag count and forces `ST_HUNT`, even in the middle of an octet.
- R9: A cycle with `bit_valid` low changes no output level, the ones count, the bit window, the octet position or the flag count. Any rise pulse from the previous cycle drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_valid | input | 1 | High when `bit_in` carries a received bit this cycle |
| bit_in | input | 1 | Received serial bit |
| mark_idle | output | 1 | Level: 15 or more consecutive ones received |
| flag_idle | output | 1 | Level: flag idle detected |
| mark_idle_rise | output | 1 | One-cycle pulse when `mark_idle` rises |
| flag_idle_rise | output | 1 | One-cycle pulse when `flag_idle` rises |

## Verification
Every result is registered. A bit sampled at one rising edge shows its effect on all four outputs right after that same edge, with no further delay. The bench therefore drives `bit_valid` and `bit_in` on the falling edge and advances its behavioural model on the rising edge that samples them. It compares every output with the model on the next falling edge, so every cycle is checked at the exact cycle its result is due. Directed sequences place the 14th, 15th and 16th ones, the second, third and fourth flags, the seventh one inside a flag stream and a non-flag octet on those sampled edges. Pauses in the strobe and mixed random traffic then run against the same model.

// File: rtl/idle_mon_pkg.sv
package idle_mon_pkg;

    typedef enum logic [1:0] {
        ST_HUNT      = 2'd0,
        ST_COUNT     = 2'd1,
        ST_FLAG_IDLE = 2'd2
    } sync_state_e;

endpackage

// File: rtl/ones_run_tracker.sv
module ones_run_tracker #(
    parameter int RUN_LEN   = 15,
    parameter int ABORT_LEN = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_valid,
    input  logic bit_in,
    output logic mark_idle,
    output logic mark_rise,
    output logic abort_hit
);
    localparam int CW = $clog2(RUN_LEN + 1);

    logic [CW-1:0] run_cnt;
    logic [CW-1:0] run_cnt_n;
    logic          reach_full;

    always_comb begin
        run_cnt_n = run_cnt;
        if (bit_valid) begin
            if (!bit_in)
                run_cnt_n = '0;
            else if (run_cnt != CW'(RUN_LEN))
                run_cnt_n = run_cnt + 1'b1;
        end
    end

    assign reach_full = bit_valid && bit_in && (run_cnt == CW'(RUN_LEN - 1));
    assign abort_hit  = bit_valid && bit_in && (run_cnt >= CW'(ABORT_LEN - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt   <= '0;
            mark_idle <= 1'b0;
            mark_rise <= 1'b0;
        end else begin
            run_cnt   <= run_cnt_n;
            mark_rise <= reach_full;
            if (bit_valid) begin
                if (!bit_in)
                    mark_idle <= 1'b0;
                else if (reach_full)
                    mark_idle <= 1'b1;
            end
        end
    end

    AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt <= CW'(RUN_LEN)); // R3
    AST_ZERO_CLEARS_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid && !bit_in |=> !mark_idle); // R3
    AST_MARK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        mark_idle |-> run_cnt == CW'(RUN_LEN)); // R2
    AST_MARK_RISE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mark_rise |=> !mark_rise); // R4
    AST_MARK_RISE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        mark_rise |-> mark_idle); // R4

endmodule

// File: rtl/octet_window.sv
module octet_window #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_valid,
    input  logic         bit_in,
    output logic [W-1:0] window
);
    logic [W-2:0] hist;

    assign window = {hist, bit_in};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hist <= '0;
        else if (bit_valid)
            hist <= window[W-2:0];
    end

    AST_WINDOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid |=> $stable(hist)); // R9

endmodule

// File: rtl/flag_sync_fsm.sv
module flag_sync_fsm
    import idle_mon_pkg::*;
#(
    parameter int          W          = 8,
    parameter logic [W-1:0] FLAG      = 8'h7E,
    parameter int          IDLE_FLAGS = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_valid,
    input  logic [W-1:0] window,
    input  logic         abort_hit,
    output logic         flag_idle,
    output logic         flag_rise
);
    localparam int BW = $clog2(W);
    localparam int FW = $clog2(IDLE_FLAGS + 1);

    sync_state_e   state, state_n;
    logic [BW-1:0] bit_cnt, bit_cnt_n;
    logic [FW-1:0] fcnt, fcnt_n;
    logic          flag_hit;
    logic          boundary;

    assign flag_hit = (window == FLAG);
    assign boundary = (bit_cnt == BW'(W - 1));

    always_comb begin
        state_n = state;
        fcnt_n  = fcnt;
        if (bit_valid) begin
            if (abort_hit) begin
                state_n = ST_HUNT;
                fcnt_n  = '0;
            end else begin
                unique case (state)
                    ST_HUNT: begin
                        if (flag_hit) begin
                            state_n = ST_COUNT;
                            fcnt_n  = '0;
                        end
                    end
                    ST_COUNT: begin
                        if (boundary) begin
                            if (!flag_hit) begin
                                state_n = ST_HUNT;
                                fcnt_n  = '0;
                            end else if (fcnt == FW'(IDLE_FLAGS - 1)) begin
                                state_n = ST_FLAG_IDLE;
                                fcnt_n  = FW'(IDLE_FLAGS);
                            end else begin
                                fcnt_n = fcnt + 1'b1;
                            end
                        end
                    end
                    ST_FLAG_IDLE: begin
                        if (boundary && !flag_hit) begin
                            state_n = ST_HUNT;
                            fcnt_n  = '0;
                        end
                    end
                    default: begin
                        state_n = ST_HUNT;
                        fcnt_n  = '0;
                    end
                endcase
            end
        end
    end

    always_comb begin
        bit_cnt_n = bit_cnt;
        if (bit_valid) begin
            if (state == ST_HUNT || state_n == ST_HUNT)
                bit_cnt_n = '0;
            else if (boundary)
                bit_cnt_n = '0;
            else
                bit_cnt_n = bit_cnt + 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_HUNT;
            bit_cnt <= '0;
            fcnt    <= '0;
        end else begin
            state   <= state_n;
            bit_cnt <= bit_cnt_n;
            fcnt    <= fcnt_n;
        end
    end

    // outputs
    assign flag_idle = (state == ST_FLAG_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag_rise <= 1'b0;
        else
            flag_rise <= (state_n == ST_FLAG_IDLE) && (state != ST_FLAG_IDLE);
    end

    AST_ABORT_TO_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
        abort_hit |=> state == ST_HUNT && !flag_idle); // R8
    AST_NONFLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid && !abort_hit && state != ST_HUNT && boundary && !flag_hit |=> !flag_idle); // R7
    AST_GAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid |=> $stable(state) && $stable(bit_cnt) && $stable(fcnt)); // R9
    AST_IDLE_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_idle) |-> $past(flag_hit && boundary && bit_valid)); // R6
    AST_FLAG_RISE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        flag_rise |=> !flag_rise); // R4
    AST_FLAG_RISE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        flag_rise |-> flag_idle); // R4
    AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        fcnt <= FW'(IDLE_FLAGS)); // R6

endmodule

// File: rtl/idle_line_monitor.sv
module idle_line_monitor #(
    parameter int          RUN_LEN    = 15,
    parameter int          ABORT_LEN  = 7,
    parameter int          OCTET      = 8,
    parameter logic [7:0]  FLAG       = 8'h7E,
    parameter int          IDLE_FLAGS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_valid,
    input  logic bit_in,
    output logic mark_idle,
    output logic flag_idle,
    output logic mark_idle_rise,
    output logic flag_idle_rise
);
    logic [OCTET-1:0] window;
    logic             abort_hit;

    ones_run_tracker #(
        .RUN_LEN  (RUN_LEN),
        .ABORT_LEN(ABORT_LEN)
    ) u_ones (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_valid(bit_valid),
        .bit_in   (bit_in),
        .mark_idle(mark_idle),
        .mark_rise(mark_idle_rise),
        .abort_hit(abort_hit)
    );

    octet_window #(
        .W(OCTET)
    ) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_valid(bit_valid),
        .bit_in   (bit_in),
        .window   (window)
    );

    flag_sync_fsm #(
        .W         (OCTET),
        .FLAG      (FLAG),
        .IDLE_FLAGS(IDLE_FLAGS)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_valid(bit_valid),
        .window   (window),
        .abort_hit(abort_hit),
        .flag_idle(flag_idle),
        .flag_rise(flag_idle_rise)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !mark_idle && !flag_idle && !mark_idle_rise && !flag_idle_rise); // R1

endmodule

// File: tb/idle_line_monitor_tb.sv
module idle_line_monitor_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_valid = 1'b0;
    logic bit_in = 1'b0;
    logic mark_idle, flag_idle, mark_idle_rise, flag_idle_rise;

    int checks = 0;
    int errors = 0;
    int gap_max = 0;
    bit finished = 1'b0;
    string cur_req = "R1";

    // behavioural reference state
    int  m_ones = 0;
    int  m_hist = 0;
    int  m_mode = 0;
    int  m_pos = 0;
    int  m_nflags = 0;
    bit  m_mark = 0, m_mrise = 0, m_fidle = 0, m_frise = 0;

    always #4 clk = ~clk;

    idle_line_monitor u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .bit_valid     (bit_valid),
        .bit_in        (bit_in),
        .mark_idle     (mark_idle),
        .flag_idle     (flag_idle),
        .mark_idle_rise(mark_idle_rise),
        .flag_idle_rise(flag_idle_rise)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ones = 0; m_hist = 0; m_mode = 0; m_pos = 0; m_nflags = 0;
            m_mark = 0; m_mrise = 0; m_fidle = 0; m_frise = 0;
        end else begin
            m_mrise = 0;
            m_frise = 0;
            if (bit_valid) begin
                m_ones = bit_in ? ((m_ones < 15) ? m_ones + 1 : 15) : 0;
                m_hist = ((m_hist << 1) | int'(bit_in)) & 255;
                if (bit_in && m_ones == 15 && !m_mark) begin
                    m_mark = 1; m_mrise = 1;
                end
                if (!bit_in) m_mark = 0;
                if (bit_in && m_ones >= 7) begin
                    m_mode = 0; m_nflags = 0; m_fidle = 0;
                end else if (m_mode == 0) begin
                    if (m_hist == 126) begin
                        m_mode = 1; m_pos = 0; m_nflags = 0;
                    end
                end else begin
                    m_pos++;
                    if (m_pos == 8) begin
                        m_pos = 0;
                        if (m_hist == 126) begin
                            if (m_nflags < 3) m_nflags++;
                            if (m_nflags >= 3 && !m_fidle) begin
                                m_fidle = 1; m_frise = 1;
                            end
                        end else begin
                            m_mode = 0; m_nflags = 0; m_fidle = 0;
                        end
                    end
                end
            end
        end
    end

    task automatic check1(string sig, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", cur_req, sig, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check1("mark_idle", mark_idle, m_mark);
        check1("mark_idle_rise", mark_idle_rise, m_mrise);
        check1("flag_idle", flag_idle, m_fidle);
        check1("flag_idle_rise", flag_idle_rise, m_frise);
    endtask

    task automatic step(bit v, bit b);
        @(negedge clk);
        compare_all();
        bit_valid = v;
        bit_in = b;
    endtask

    task automatic send_bit(bit b);
        if (gap_max > 0) begin
            int g = $urandom_range(gap_max, 0);
            for (int k = 0; k < g; k++) step(1'b0, $urandom_range(1, 0) == 1);
        end
        step(1'b1, b);
    endtask

    task automatic send_byte(logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic send_ones(int n);
        for (int i = 0; i < n; i++) send_bit(1'b1);
    endtask

    task automatic settle();
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
    endtask

    initial begin : watchdog
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (finished) disable watchdog;
        end
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        repeat (3) @(negedge clk);
        check1("mark_idle", mark_idle, 1'b0);
        check1("flag_idle", flag_idle, 1'b0);
        check1("mark_idle_rise", mark_idle_rise, 1'b0);
        check1("flag_idle_rise", flag_idle_rise, 1'b0);
        rst_n = 1'b1;
        step(1'b0, 1'b0);

        // R3: 14 ones then a zero never sets mark idle
        cur_req = "R3";
        send_ones(14);
        send_bit(1'b0);
        settle();
        // R2: 15th one sets mark idle, more ones keep it
        cur_req = "R2";
        send_ones(20);
        settle();
        // R3: zero clears it; long run saturates
        cur_req = "R3";
        send_bit(1'b0);
        send_ones(40);
        send_bit(1'b0);
        settle();

        // R5/R6: data, closing flag, then counted flags
        cur_req = "R5";
        send_byte(8'h00);
        send_byte(8'h7E);
        send_byte(8'h7E);
        cur_req = "R6";
        send_byte(8'h7E);
        send_byte(8'h7E);
        cur_req = "R4";
        send_byte(8'h7E);
        send_byte(8'h7E);
        settle();
        // R7: non-flag octet clears flag idle
        cur_req = "R7";
        send_byte(8'h12);
        send_byte(8'h7E);
        send_byte(8'h7E);
        send_byte(8'h7E);
        send_byte(8'h3C);
        settle();

        // R8: abort in the middle of a flag stream
        cur_req = "R8";
        for (int i = 0; i < 5; i++) send_byte(8'h7E);
        send_ones(7);
        send_bit(1'b0);
        for (int i = 0; i < 5; i++) send_byte(8'h7E);
        send_ones(3);
        send_ones(9);
        send_bit(1'b0);
        settle();

        // R9: pauses between bits
        cur_req = "R9";
        gap_max = 3;
        send_byte(8'h00);
        for (int i = 0; i < 6; i++) send_byte(8'h7E);
        send_ones(18);
        send_bit(1'b0);
        send_byte(8'hA5);
        gap_max = 0;
        settle();

        // mixed random traffic
        cur_req = "R6";
        for (int n = 0; n < 1500; n++) begin
            int sel = $urandom_range(9, 0);
            gap_max = (n % 3 == 0) ? 2 : 0;
            if (sel < 5) send_byte(8'h7E);
            else if (sel < 6) send_ones($urandom_range(20, 5));
            else send_byte(8'($urandom_range(255, 0)));
        end
        gap_max = 0;
        settle();

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule